// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block keeps the state of a bank of interrupt levels, built in groups of sixteen, and decides which one the processor should service next. Every level carries two independent controls. *Arm* decides whether the level listens to its request line at all. *Enable* decides whether a request the level holds may be offered to the processor. Software can raise any level itself through a control write. It can also read the full state of one group and later write that state back.

Level number sets priority, and level 0 is the most urgent. A level that holds a request and is enabled is offered on `irq_req`/`irq_level` only when no level of equal or higher priority is already being serviced. The processor takes the offered level with `cpu_ack`. It retires the most urgent level in service with `cpu_clr`. Control writes name one group and carry a 16-bit mask or data word. Each bit of that word maps to one level of the group: level = group*16 + bit.

Top module: `intlvl_ctrl`

## Requirements
- R1: After reset every level is disarmed, disabled, not waiting and not active, and `irq_req` is low.
- R2: A level that is not armed ignores its external request line and the software trigger; its waiting bit stays clear.
- R3: An armed level that sees a request sets its waiting bit even when disabled, but is not offered until enabled; once enabled it is offered.
- R4: Control op 5 (trigger) sets waiting on the armed levels selected by `ctl_data_a`, exactly like an external request. A trigger and an external request on the same level in the same cycle leave one waiting request, serviced once.
- R5: Among enabled waiting levels, the lowest level number is offered, across group boundaries.
- R6: A level is offered only if no active level has an equal or lower number; `irq_level` gives the offered level while `irq_req` is high.
- R7: `cpu_ack` while `irq_req` is high makes the offered level active and clears its waiting bit from the next cycle.
- R8: `cpu_clr` clears the active bit of the lowest-numbered active level, effective next cycle.
- R9: The readback outputs show the arm, enable, waiting and active bits of group `rd_group` in the current cycle.
- R10: Op 6 loads arm from `ctl_data_a` and enable from `ctl_data_b`. Op 7 loads waiting from `ctl_data_a` and active from `ctl_data_b`. Each load applies to the selected group and overrides every other change to that group in that cycle.
- R11: Ops 1/2/3/4 set arm, clear arm, set enable and clear enable on the masked levels. Clearing arm also discards a held waiting request. A request to a level that is already active is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 32 | External request lines, one per level, level-sensitive |
| ctl_we | input | 1 | Control write strobe |
| ctl_op | input | 3 | Control operation code (1..7) |
| ctl_group | input | 1 | Group addressed by the control write |
| ctl_data_a | input | 16 | Mask for ops 1-5, first data word for loads |
| ctl_data_b | input | 16 | Second data word for loads |
| cpu_ack | input | 1 | Processor takes the offered level |
| cpu_clr | input | 1 | Processor retires the most urgent active level |
| irq_req | output | 1 | A level is offered |
| irq_level | output | 5 | Number of the offered level |
| rd_group | input | 1 | Group shown on the readback outputs |
| rd_armed | output | 16 | Arm bits of the readback group |
| rd_enabled | output | 16 | Enable bits of the readback group |
| rd_waiting | output | 16 | Waiting bits of the readback group |
| rd_active | output | 16 | Active bits of the readback group |

## Verification
The assertions assume that `cpu_ack` arrives only while a level is offered. They also excuse cycles in which a state load hits the group, since a load may rewrite any bit. The clear property relies on `cpu_clr` being issued with no acknowledge in the same cycle. The stimulus therefore raises `cpu_ack` only when the bench's own model shows an offered level, and raises `cpu_clr` only when that model holds an active level. Its random phase still mixes loads, triggers and line activity freely, so the excused cycles do occur.

// File: rtl/intlvl_pkg.sv
package intlvl_pkg;

   localparam int LEVELS_PER_GROUP = 16;

   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_ARM     = 3'd1,
      OP_DISARM  = 3'd2,
      OP_ENABLE  = 3'd3,
      OP_DISABLE = 3'd4,
      OP_TRIG    = 3'd5,
      OP_LOAD_AE = 3'd6,
      OP_LOAD_WA = 3'd7
   } ctl_op_e;

endpackage

// File: rtl/intlvl_first.sv
// Lowest-index set bit finder; index 0 is the most urgent.
module intlvl_first #(
   parameter int W  = 32,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);

   generate
      if (W < 1) begin : g_bad_w
         $error("intlvl_first: W must be at least 1");
      end
   endgenerate

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/intlvl_group.sv
// State of one group of levels: arm, enable, waiting, active.
module intlvl_group
   import intlvl_pkg::*;
#(
   parameter int GW = LEVELS_PER_GROUP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [GW-1:0] ext_req,
   input  logic          sel,
   input  ctl_op_e       op,
   input  logic [GW-1:0] data_a,
   input  logic [GW-1:0] data_b,
   input  logic [GW-1:0] ack_vec,
   input  logic [GW-1:0] clr_vec,
   output logic [GW-1:0] armed,
   output logic [GW-1:0] enabled,
   output logic [GW-1:0] waiting,
   output logic [GW-1:0] active
);

   logic [GW-1:0] set_arm, clr_arm, set_en, clr_en, trig, hit;
   logic [GW-1:0] arm_n, en_n, wait_n, act_n;
   logic          ld_ae, ld_wa;

   always_comb begin
      set_arm = (sel && op == OP_ARM)     ? data_a : '0;
      clr_arm = (sel && op == OP_DISARM)  ? data_a : '0;
      set_en  = (sel && op == OP_ENABLE)  ? data_a : '0;
      clr_en  = (sel && op == OP_DISABLE) ? data_a : '0;
      trig    = (sel && op == OP_TRIG)    ? data_a : '0;
      ld_ae   = sel && (op == OP_LOAD_AE);
      ld_wa   = sel && (op == OP_LOAD_WA);
      // external line and trigger merge into one request per level
      hit     = armed & (ext_req | trig) & ~active & ~ack_vec;
      arm_n   = ld_ae ? data_a : ((armed | set_arm) & ~clr_arm);
      en_n    = ld_ae ? data_b : ((enabled | set_en) & ~clr_en);
      wait_n  = ld_wa ? data_a : (((waiting & ~ack_vec) | hit) & ~clr_arm);
      act_n   = ld_wa ? data_b : ((active | ack_vec) & ~clr_vec);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed   <= '0;
         enabled <= '0;
         waiting <= '0;
         active  <= '0;
      end else begin
         armed   <= arm_n;
         enabled <= en_n;
         waiting <= wait_n;
         active  <= act_n;
      end
   end

   // R2: a level that was not armed never gains a waiting request
   p_disarmed_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($past(ld_wa) || ((waiting & ~$past(waiting) & ~$past(armed)) == '0)));

   // R11: an active level does not take a new request
   p_active_drops_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($past(ld_wa) || ((waiting & ~$past(waiting) & $past(active)) == '0)));

endmodule

// File: rtl/intlvl_ctrl.sv
module intlvl_ctrl
   import intlvl_pkg::*;
#(
   parameter int GROUPS  = 2,
   parameter int GROUP_W = LEVELS_PER_GROUP,
   parameter int NLEV    = GROUPS * GROUP_W,
   parameter int LW      = (NLEV > 1) ? $clog2(NLEV) : 1,
   parameter int GSW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NLEV-1:0]    ext_req,
   input  logic               ctl_we,
   input  logic [2:0]         ctl_op,
   input  logic [GSW-1:0]     ctl_group,
   input  logic [GROUP_W-1:0] ctl_data_a,
   input  logic [GROUP_W-1:0] ctl_data_b,
   input  logic               cpu_ack,
   input  logic               cpu_clr,
   output logic               irq_req,
   output logic [LW-1:0]      irq_level,
   input  logic [GSW-1:0]     rd_group,
   output logic [GROUP_W-1:0] rd_armed,
   output logic [GROUP_W-1:0] rd_enabled,
   output logic [GROUP_W-1:0] rd_waiting,
   output logic [GROUP_W-1:0] rd_active
);

   generate
      if (GROUP_W != LEVELS_PER_GROUP) begin : g_bad_gw
         $error("intlvl_ctrl: groups hold exactly 16 levels");
      end
      if (GROUPS < 1) begin : g_bad_groups
         $error("intlvl_ctrl: at least one group is needed");
      end
   endgenerate

   ctl_op_e            op;
   logic [NLEV-1:0]    arm_all, en_all, wait_all, act_all;
   logic [NLEV-1:0]    pend, ack_all, clr_all;
   logic               p_found, a_found, take;
   logic [LW-1:0]      p_idx, a_idx;
   logic [GROUP_W-1:0] g_arm  [GROUPS];
   logic [GROUP_W-1:0] g_en   [GROUPS];
   logic [GROUP_W-1:0] g_wait [GROUPS];
   logic [GROUP_W-1:0] g_act  [GROUPS];

   assign op = ctl_op_e'(ctl_op);

   generate
      for (genvar g = 0; g < GROUPS; g++) begin : g_grp
         intlvl_group #(.GW(GROUP_W)) i_group (
            .clk     (clk),
            .rst_n   (rst_n),
            .ext_req (ext_req[g*GROUP_W +: GROUP_W]),
            .sel     (ctl_we && (ctl_group == GSW'(g))),
            .op      (op),
            .data_a  (ctl_data_a),
            .data_b  (ctl_data_b),
            .ack_vec (ack_all[g*GROUP_W +: GROUP_W]),
            .clr_vec (clr_all[g*GROUP_W +: GROUP_W]),
            .armed   (g_arm[g]),
            .enabled (g_en[g]),
            .waiting (g_wait[g]),
            .active  (g_act[g])
         );
         assign arm_all [g*GROUP_W +: GROUP_W] = g_arm[g];
         assign en_all  [g*GROUP_W +: GROUP_W] = g_en[g];
         assign wait_all[g*GROUP_W +: GROUP_W] = g_wait[g];
         assign act_all [g*GROUP_W +: GROUP_W] = g_act[g];
      end
   endgenerate

   assign pend = wait_all & en_all;

   intlvl_first #(.W(NLEV), .IW(LW)) i_pend_first (
      .vec   (pend),
      .found (p_found),
      .idx   (p_idx)
   );

   intlvl_first #(.W(NLEV), .IW(LW)) i_act_first (
      .vec   (act_all),
      .found (a_found),
      .idx   (a_idx)
   );

   always_comb begin
      irq_req   = p_found && (!a_found || (p_idx < a_idx));
      irq_level = p_idx;
      take      = cpu_ack && irq_req;
      ack_all   = take ? (NLEV'(1) << p_idx) : '0;
      clr_all   = (cpu_clr && a_found) ? (NLEV'(1) << a_idx) : '0;
   end

   assign rd_armed   = g_arm[rd_group];
   assign rd_enabled = g_en[rd_group];
   assign rd_waiting = g_wait[rd_group];
   assign rd_active  = g_act[rd_group];

   logic any_load;
   assign any_load = ctl_we && (ctl_op[2:1] == 2'b11);

   // R6: an offered level is enabled, waiting and not yet in service
   p_offer_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (wait_all[irq_level] && en_all[irq_level] && !act_all[irq_level]));

   // R7: acknowledge moves the offered level into service
   p_ack_activates_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack && irq_req && !any_load) |=>
         (act_all[$past(irq_level)] && !wait_all[$past(irq_level)]));

   // R8: clear retires exactly one active level
   p_clear_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clr && (act_all != '0) && !any_load && !(cpu_ack && irq_req)) |=>
         ($countones(act_all) == $countones($past(act_all)) - 1));

   // R1: nothing is offered in the first cycle after reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !irq_req);

endmodule

// File: tb/test_intlvl_ctrl.sv
module test_intlvl_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NLEV = 32;
   localparam int GW   = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] ext_req;
   logic        ctl_we;
   logic [2:0]  ctl_op;
   logic [0:0]  ctl_group;
   logic [15:0] ctl_data_a, ctl_data_b;
   logic        cpu_ack, cpu_clr;
   logic        irq_req;
   logic [4:0]  irq_level;
   logic [0:0]  rd_group;
   logic [15:0] rd_armed, rd_enabled, rd_waiting, rd_active;

   int checks = 0;
   int fails  = 0;

   bit [31:0] m_arm, m_en, m_wait, m_act;

   always #(CLK_PERIOD/2) clk = ~clk;

   intlvl_ctrl i_intlvl_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ctl_we(ctl_we),
      .ctl_op(ctl_op), .ctl_group(ctl_group), .ctl_data_a(ctl_data_a),
      .ctl_data_b(ctl_data_b), .cpu_ack(cpu_ack), .cpu_clr(cpu_clr),
      .irq_req(irq_req), .irq_level(irq_level), .rd_group(rd_group),
      .rd_armed(rd_armed), .rd_enabled(rd_enabled), .rd_waiting(rd_waiting),
      .rd_active(rd_active)
   );

   function automatic void m_offer(output bit req, output int lvl);
      int p = -1;
      int a = -1;
      for (int i = NLEV - 1; i >= 0; i--) begin
         if (m_wait[i] && m_en[i]) p = i;
         if (m_act[i]) a = i;
      end
      req = (p >= 0) && (a < 0 || p < a);
      lvl = (p >= 0) ? p : 0;
   endfunction

   function automatic int m_first_act();
      int a = -1;
      for (int i = NLEV - 1; i >= 0; i--) if (m_act[i]) a = i;
      return a;
   endfunction

   task automatic model_step();
      bit req;
      int lvl, a, g, b;
      bit [31:0] na, ne, nw, nt;
      m_offer(req, lvl);
      a = m_first_act();
      if (!rst_n) begin
         m_arm = '0; m_en = '0; m_wait = '0; m_act = '0;
         return;
      end
      for (int i = 0; i < NLEV; i++) begin
         bit sel, mk, ackb, clrb, trg, hit;
         g = i / GW; b = i % GW;
         sel  = ctl_we && (ctl_group == g[0:0]);
         mk   = ctl_data_a[b];
         ackb = cpu_ack && req && (lvl == i);
         clrb = cpu_clr && (a == i);
         trg  = sel && ctl_op == 3'd5 && mk;
         hit  = m_arm[i] && (ext_req[i] || trg) && !m_act[i] && !ackb;
         if (sel && ctl_op == 3'd6) begin
            na[i] = ctl_data_a[b]; ne[i] = ctl_data_b[b];
         end else begin
            na[i] = (m_arm[i] || (sel && ctl_op == 3'd1 && mk)) && !(sel && ctl_op == 3'd2 && mk);
            ne[i] = (m_en[i]  || (sel && ctl_op == 3'd3 && mk)) && !(sel && ctl_op == 3'd4 && mk);
         end
         if (sel && ctl_op == 3'd7) begin
            nw[i] = ctl_data_a[b]; nt[i] = ctl_data_b[b];
         end else begin
            nw[i] = ((m_wait[i] && !ackb) || hit) && !(sel && ctl_op == 3'd2 && mk);
            nt[i] = (m_act[i] || ackb) && !clrb;
         end
      end
      m_arm = na; m_en = ne; m_wait = nw; m_act = nt;
   endtask

   task automatic compare(string tag);
      bit req;
      int lvl;
      bit [15:0] e_arm, e_en, e_wait, e_act;
      m_offer(req, lvl);
      e_arm  = m_arm [rd_group*16 +: 16];
      e_en   = m_en  [rd_group*16 +: 16];
      e_wait = m_wait[rd_group*16 +: 16];
      e_act  = m_act [rd_group*16 +: 16];
      checks++;
      if (irq_req !== req || (req && irq_level !== lvl[4:0]) ||
          rd_armed !== e_arm || rd_enabled !== e_en ||
          rd_waiting !== e_wait || rd_active !== e_act) begin
         fails++;
         $display("FAIL %s: got req=%0b lvl=%0d arm=%h en=%h wait=%h act=%h exp req=%0b lvl=%0d arm=%h en=%h wait=%h act=%h",
                  tag, irq_req, irq_level, rd_armed, rd_enabled, rd_waiting, rd_active,
                  req, lvl, e_arm, e_en, e_wait, e_act);
      end
   endtask

   task automatic idle_inputs();
      ext_req = '0; ctl_we = 1'b0; ctl_op = 3'd0; ctl_group = 1'b0;
      ctl_data_a = '0; ctl_data_b = '0; cpu_ack = 1'b0; cpu_clr = 1'b0;
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
      idle_inputs();
   endtask

   task automatic wr(logic [2:0] op, logic g, logic [15:0] a, logic [15:0] b, string tag);
      ctl_we = 1'b1; ctl_op = op; ctl_group = g; ctl_data_a = a; ctl_data_b = b;
      tick(tag);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: got running exp finished");
      finish_run();
   end

   initial begin
      idle_inputs();
      rd_group = 1'b0;
      rst_n = 1'b0;
      m_arm = '0; m_en = '0; m_wait = '0; m_act = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick("R1 reset state");
      rd_group = 1'b1;
      tick("R1 reset state group1");
      rd_group = 1'b0;

      // R2: disarmed levels ignore lines and triggers
      ext_req = '1; tick("R2 line on disarmed");
      wr(3'd3, 1'b0, 16'hffff, 16'h0, "R2 enable while disarmed");
      wr(3'd5, 1'b0, 16'hffff, 16'h0, "R2 trigger on disarmed");
      ext_req = '1; tick("R2 line on disarmed enabled");
      wr(3'd4, 1'b0, 16'hffff, 16'h0, "R11 disable all");

      // R3: armed but disabled holds the request
      wr(3'd1, 1'b0, 16'h0030, 16'h0, "R11 arm 4 and 5");
      ext_req = 32'h20; tick("R3 latch while disabled");
      tick("R3 held, not offered");
      wr(3'd3, 1'b0, 16'h0020, 16'h0, "R3 enable 5");
      tick("R3 level 5 offered");

      // R7 / R4 / R6 / R8 / R11
      cpu_ack = 1'b1; tick("R7 ack level 5");
      wr(3'd3, 1'b0, 16'h0010, 16'h0, "R6 enable 4");
      wr(3'd5, 1'b0, 16'h0010, 16'h0, "R4 trigger level 4");
      tick("R6 level 4 above active 5");
      cpu_ack = 1'b1; tick("R7 ack level 4");
      ext_req = 32'h30; tick("R11 request to active levels dropped");
      cpu_clr = 1'b1; tick("R8 clear level 4");
      cpu_clr = 1'b1; tick("R8 clear level 5");

      // R5: priority across groups
      wr(3'd1, 1'b0, 16'hffff, 16'h0, "R11 arm group0");
      wr(3'd1, 1'b1, 16'hffff, 16'h0, "R11 arm group1");
      wr(3'd3, 1'b0, 16'hffff, 16'h0, "R11 enable group0");
      wr(3'd3, 1'b1, 16'hffff, 16'h0, "R11 enable group1");
      rd_group = 1'b1;
      ext_req = 32'h4002_0008; tick("R5 three requests");
      cpu_ack = 1'b1; tick("R5 ack level 3");
      tick("R6 level 17 held behind active 3");
      cpu_clr = 1'b1; tick("R8 clear 3");
      tick("R5 level 17 offered");
      cpu_ack = 1'b1; tick("R7 ack 17");
      cpu_clr = 1'b1; tick("R8 clear 17");
      cpu_ack = 1'b1; tick("R5 ack 30");
      cpu_clr = 1'b1; tick("R8 clear 30");

      // R4: merge of line and trigger on level 20
      ext_req = 32'h0010_0000; ctl_we = 1'b1; ctl_op = 3'd5; ctl_group = 1'b1;
      ctl_data_a = 16'h0010; tick("R4 line plus trigger");
      cpu_ack = 1'b1; tick("R4 ack level 20");
      cpu_clr = 1'b1; tick("R4 clear level 20");
      tick("R4 single service");

      // R11: disarm discards waiting
      rd_group = 1'b0;
      wr(3'd4, 1'b0, 16'h0200, 16'h0, "R11 disable 9");
      ext_req = 32'h200; tick("R11 level 9 waits");
      wr(3'd2, 1'b0, 16'h0200, 16'h0, "R11 disarm drops 9");
      wr(3'd3, 1'b0, 16'h0200, 16'h0, "R11 re-enable 9");

      // R10 / R9: restore
      rd_group = 1'b1;
      wr(3'd6, 1'b1, 16'h00ff, 16'h000f, "R10 load arm/enable");
      wr(3'd7, 1'b1, 16'h0003, 16'h0100, "R10 load waiting/active");
      tick("R9 readback after restore");
      rd_group = 1'b0;
      tick("R9 readback group0");

      // mixed random traffic against the model
      for (int n = 0; n < 600; n++) begin
         bit req;
         int lvl;
         m_offer(req, lvl);
         rd_group   = $urandom_range(0, 1);
         ext_req    = $urandom() & $urandom() & $urandom();
         ctl_we     = ($urandom_range(0, 3) == 0);
         ctl_op     = $urandom_range(1, 7);
         ctl_group  = $urandom_range(0, 1);
         ctl_data_a = $urandom();
         ctl_data_b = $urandom();
         cpu_ack    = req && ($urandom_range(0, 1) == 1);
         cpu_clr    = (m_first_act() >= 0) && ($urandom_range(0, 2) == 0);
         tick("R6 random traffic");
      end

      finish_run();
   end

endmodule